// File: doc/BRIEF.md
# SPI Flash Sector Erase Sequencer

This block erases a range of a serial NOR flash one sector at a time. A single-cycle request carries a byte start address and a byte length. The block first checks the request against the erase-sector size and the device capacity. Both are parameters: the sector is 32 KiB or 64 KiB, and the capacity is the sector size times the sector count. A rejected request ends with an invalid-argument pulse and produces no bus activity. An accepted request with zero length ends with a success pulse, also without bus activity.

For every sector of an accepted range, the block reads the flash status byte until the busy flag clears. It then sends a one-byte write-enable frame, followed by a four-byte sector-erase frame that carries a 24-bit address. The address steps forward by one sector size until the whole range has been erased. If the flash stays busy for a set number of status reads, the rest of the range is dropped and an I/O error pulse is raised. The SPI master inside the block works in mode 0, sends the most significant bit first and holds chip select low for exactly one frame.

Top module: `spi_erase_seq`

## Requirements
- R1: A request whose start plus length exceeds the device capacity (sector size times sector count) ends with one `err_inval` pulse and no chip-select activity, even if the length is zero.
- R2: A request whose start or length is not a multiple of the sector size ends with one `err_inval` pulse and no chip-select activity.
- R3: A valid request with zero length ends with one `done` pulse and no chip-select activity.
- R4: Before each sector, the block sends status-read frames of two bytes (opcode 0x05 then one byte read back). Bit 0 of the byte read back means busy. The frames repeat until that bit reads 0.
- R5: After the ready status, the block sends a write-enable frame of exactly one byte, opcode 0x06, as its own chip-select frame.
- R6: The erase frame is four bytes: opcode 0xD8, then address bits 23:16, 15:8 and 7:0, each byte sent MSB first.
- R7: The first erase address is the start address, and each later one is the previous address plus one sector size. The number of erase frames equals length divided by sector size, and `done` follows the last erase frame.
- R8: If POLL_LIMIT consecutive status reads for one sector all report busy, the block pulses `err_io` and sends no more frames for that request.
- R9: Every accepted request ends with exactly one of `done`, `err_inval` or `err_io`, and never two at once. `busy` stays high from acceptance to that pulse. A request raised while `busy` is high is ignored.
- R10: After reset, `spi_cs_n` is high and `spi_sclk`, `busy` and all three result outputs are low.
- R11: The SPI clock is low whenever chip select is high, and MOSI does not change while the SPI clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_start | input | 24 | Byte start address |
| req_len | input | 25 | Byte length |
| busy | output | 1 | Request in progress |
| done | output | 1 | Success pulse |
| err_inval | output | 1 | Argument rejection pulse |
| err_io | output | 1 | Ready-timeout pulse |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench uses a flash model that stays busy for a few status reads after each erase. It aims at the edges of the argument check:
- A range that ends exactly at the capacity. A design with an off-by-one compare would reject it.
- A range one sector too long, and a zero-length request whose start lies past the end. A design that skips the range check when the length is zero would accept the second one.
- A start or a length that is off by half a sector. A design that checks only one of the two would let erase traffic through.

The bench follows every frame of a full-device erase to catch address stepping or sector counts that are off by one. It makes the flash time out both on the first sector and after one sector has been erased, so a design that carries on past a timeout is caught. It also raises a second request while the block is busy; a design that takes that request would show a stray erase frame or a second result pulse.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam int ADDR_W = 24;
  localparam logic [7:0] OP_STATUS     = 8'h05;
  localparam logic [7:0] OP_WEN        = 8'h06;
  localparam logic [7:0] OP_SECT_ERASE = 8'hD8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_POLL, ST_POLL_W,
    ST_WEN, ST_WEN_W, ST_ERASE, ST_ERASE_W
  } seq_state_t;
endpackage

// File: rtl/erase_arg_check.sv
module erase_arg_check #(
  parameter int SECT_LOG2  = 16,
  parameter int SECT_COUNT = 16,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 25
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [LEN_W-1:0]  len,
  output logic              ok,
  output logic              zero
);
  localparam int SUM_W = LEN_W + 1;
  localparam logic [SUM_W-1:0] DEV_BYTES = SUM_W'(SECT_COUNT) << SECT_LOG2;

  logic [SUM_W-1:0] end_addr;
  logic             aligned;

  assign end_addr = SUM_W'(start) + SUM_W'(len);

  generate
    if (SECT_LOG2 > 0) begin : g_align
      assign aligned = (start[SECT_LOG2-1:0] == '0) && (len[SECT_LOG2-1:0] == '0);
    end else begin : g_noalign
      assign aligned = 1'b1;
    end
  endgenerate

  assign ok   = aligned && (end_addr <= DEV_BYTES);
  assign zero = (len == '0);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  nbytes,
  input  logic [31:0] tx,
  input  logic        miso,
  output logic        done,
  output logic [7:0]  rx,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          active;
  logic [31:0]   sh;
  logic [5:0]    bits;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      sh     <= '0;
      bits   <= '0;
      cnt    <= '0;
      rx     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sh     <= tx;
          bits   <= {nbytes, 3'b000};
          cnt    <= '0;
        end
      end else if (cnt == CW'(DIV - 1)) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          sh   <= {sh[30:0], 1'b0};
          bits <= bits - 6'd1;
          if (bits == 6'd1) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign mosi = sh[31];

  // R11
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R11
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq import erase_seq_pkg::*; #(
  parameter int SECT_LOG2  = 16,
  parameter int SECT_COUNT = 16,
  parameter int POLL_LIMIT = 8,
  parameter int SCLK_DIV   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W:0]   req_len,
  output logic              busy,
  output logic              done,
  output logic              err_inval,
  output logic              err_io,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int LEN_W = ADDR_W + 1;
  localparam int PW    = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;
  localparam logic [LEN_W-1:0] SECT_BYTES = LEN_W'(1) << SECT_LOG2;

  seq_state_t        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [PW-1:0]     poll_cnt;
  logic              f_start, f_done;
  logic [2:0]        f_nbytes;
  logic [31:0]       f_tx;
  logic [7:0]        f_rx;
  logic              arg_ok, arg_zero;
  logic              wen_ok;
  logic              traffic;

  erase_arg_check #(
    .SECT_LOG2(SECT_LOG2), .SECT_COUNT(SECT_COUNT),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_check (
    .start(cur_addr), .len(remain), .ok(arg_ok), .zero(arg_zero)
  );

  spi_frame_shifter #(.DIV(SCLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(f_start), .nbytes(f_nbytes), .tx(f_tx),
    .miso(spi_miso), .done(f_done), .rx(f_rx),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_addr  <= '0;
      remain    <= '0;
      poll_cnt  <= '0;
      f_start   <= 1'b0;
      f_nbytes  <= '0;
      f_tx      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_inval <= 1'b0;
      err_io    <= 1'b0;
      wen_ok    <= 1'b0;
    end else begin
      f_start   <= 1'b0;
      done      <= 1'b0;
      err_inval <= 1'b0;
      err_io    <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr <= req_start;
          remain   <= req_len;
          busy     <= 1'b1;
          state    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!arg_ok) begin
            err_inval <= 1'b1;
            busy      <= 1'b0;
            state     <= ST_IDLE;
          end else if (arg_zero) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            poll_cnt <= '0;
            state    <= ST_POLL;
          end
        end
        ST_POLL: begin
          f_start  <= 1'b1;
          f_nbytes <= 3'd2;
          f_tx     <= {OP_STATUS, 24'h0};
          state    <= ST_POLL_W;
        end
        ST_POLL_W: if (f_done) begin
          if (!f_rx[0]) begin
            state <= ST_WEN;
          end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
            err_io <= 1'b1;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            poll_cnt <= poll_cnt + PW'(1);
            state    <= ST_POLL;
          end
        end
        ST_WEN: begin
          f_start  <= 1'b1;
          f_nbytes <= 3'd1;
          f_tx     <= {OP_WEN, 24'h0};
          state    <= ST_WEN_W;
        end
        ST_WEN_W: if (f_done) begin
          wen_ok <= 1'b1;
          state  <= ST_ERASE;
        end
        ST_ERASE: begin
          f_start  <= 1'b1;
          f_nbytes <= 3'd4;
          f_tx     <= {OP_SECT_ERASE, cur_addr};
          wen_ok   <= 1'b0;
          state    <= ST_ERASE_W;
        end
        ST_ERASE_W: if (f_done) begin
          cur_addr <= cur_addr + SECT_BYTES[ADDR_W-1:0];
          remain   <= remain - SECT_BYTES;
          if (remain == SECT_BYTES) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            poll_cnt <= '0;
            state    <= ST_POLL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            traffic <= 1'b0;
    else if (state == ST_IDLE && req_valid) traffic <= 1'b0;
    else if (!spi_cs_n)                 traffic <= 1'b1;
  end

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err_inval, err_io}));

  // R1 and R2
  inval_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_inval |-> !traffic);

  // R3
  zero_len_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(state) == ST_CHECK) |-> !traffic);

  // R5
  wen_before_erase_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE) |-> wen_ok);

  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < PW'(POLL_LIMIT));
endmodule

// File: tb/sim_spi_erase_seq.sv
module sim_spi_erase_seq;
  localparam int S = 32'h10000;
  localparam int NV = 9;
  localparam int V_START [NV] = '{32'h000000, 32'h020000, 32'h0F0000, 32'h0F0000,
                                  32'h008000, 32'h000000, 32'h050000, 32'h000000, 32'h110000};
  localparam int V_LEN   [NV] = '{32'h10000, 32'h30000, 32'h10000, 32'h20000,
                                  32'h10000, 32'h18000, 32'h0, 32'h100000, 32'h0};
  localparam int V_RES   [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 1};
  localparam string V_TAG [NV] = '{"R7", "R7", "R1", "R1", "R2", "R2", "R3", "R7", "R1"};

  logic clk = 0, rst = 1, req_valid = 0;
  logic [23:0] req_start = '0;
  logic [24:0] req_len = '0;
  logic busy, done, err_inval, err_io, sclk, cs_n, mosi, miso;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_erase_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_start(req_start), .req_len(req_len),
    .busy(busy), .done(done), .err_inval(err_inval), .err_io(err_io),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
  );

  // flash model and frame log
  int bitn = 0, busy_left = 0, erase_busy = 2, nfr = 0, npulse = 0, idle_viol = 0;
  logic [7:0] shreg = '0, stat_now = '0;
  logic [7:0] cur_b [4];
  int fl_len [128];
  logic [7:0] fl_b0 [128];
  logic [23:0] fl_addr [128];
  logic fl_busy [128];

  assign miso = (bitn >= 8 && bitn < 16) ? stat_now[15 - bitn] : 1'b0;

  always @(negedge cs_n) begin
    bitn = 0;
    stat_now = (busy_left > 0) ? 8'h01 : 8'h00;
  end

  always @(posedge sclk) if (!cs_n) begin
    shreg = {shreg[6:0], mosi};
    bitn = bitn + 1;
    if (bitn % 8 == 0 && bitn <= 32) cur_b[bitn/8 - 1] = shreg;
  end

  always @(posedge cs_n) if (bitn > 0) begin
    if (nfr < 128) begin
      fl_len[nfr]  = bitn / 8;
      fl_b0[nfr]   = cur_b[0];
      fl_addr[nfr] = {cur_b[1], cur_b[2], cur_b[3]};
      fl_busy[nfr] = stat_now[0];
    end
    nfr = nfr + 1;
    if (cur_b[0] == 8'h05 && busy_left > 0) busy_left = busy_left - 1;
    if (cur_b[0] == 8'hD8) busy_left = erase_busy;
    bitn = 0;
  end

  always @(posedge clk) if (!rst && (done || err_inval || err_io)) npulse++;
  always @(negedge clk) if (!rst && cs_n && sclk) idle_viol++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input int st, input int ln, output int code);
    int n;
    nfr = 0;
    @(negedge clk);
    req_valid = 1; req_start = st[23:0]; req_len = ln[24:0];
    @(negedge clk);
    req_valid = 0;
    code = 3;
    n = 0;
    while (code == 3 && n < 20000) begin
      if (done) code = 0;
      else if (err_inval) code = 1;
      else if (err_io) code = 2;
      else begin @(negedge clk); n++; end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic verify_erase(input int st, input int nsec);
    int p = 0;
    for (int s = 0; s < nsec; s++) begin
      while (p < nfr && p < 127 && fl_b0[p] == 8'h05 && fl_busy[p]) p++;
      chk(p < nfr && fl_b0[p] == 8'h05 && fl_len[p] == 2 && !fl_busy[p], "R4", fl_b0[p], 8'h05);
      p++;
      chk(p < nfr && fl_b0[p] == 8'h06 && fl_len[p] == 1, "R5", {fl_len[p], fl_b0[p]}, {1, 8'h06});
      p++;
      chk(p < nfr && fl_b0[p] == 8'hD8 && fl_len[p] == 4, "R6", {fl_len[p], fl_b0[p]}, {4, 8'hD8});
      chk(fl_addr[p] == 24'(st + s * S), "R7", fl_addr[p], st + s * S);
      p++;
    end
    chk(nfr == p, "R7", nfr, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int code;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R10", {cs_n, sclk, busy}, 3'b100);
    chk({done, err_inval, err_io} === 3'b000, "R10", {done, err_inval, err_io}, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_req(V_START[v], V_LEN[v], code);
      chk(code == V_RES[v], V_TAG[v], code, V_RES[v]);
      if (V_RES[v] == 0 && V_LEN[v] != 0) verify_erase(V_START[v], V_LEN[v] / S);
      else chk(nfr == 0, V_TAG[v], nfr, 0);
    end

    // R9: request while busy is ignored
    nfr = 0; npulse = 0;
    @(negedge clk);
    req_valid = 1; req_start = 24'h040000; req_len = 25'h10000;
    @(negedge clk); req_valid = 0;
    repeat (5) @(negedge clk);
    chk(busy === 1'b1, "R9", busy, 1);
    req_valid = 1; req_start = 24'h008000; req_len = 25'h0;
    @(negedge clk); req_valid = 0;
    while (!done && !err_inval && !err_io) @(negedge clk);
    chk(done === 1'b1, "R9", {done, err_inval, err_io}, 3'b100);
    repeat (300) @(negedge clk);
    chk(npulse == 1 && busy === 1'b0, "R9", npulse, 1);
    verify_erase(32'h040000, 1);

    // R8: timeout on first sector
    busy_left = 50; erase_busy = 2;
    run_req(0, 2 * S, code);
    chk(code == 2, "R8", code, 2);
    chk(nfr == 8, "R8", nfr, 8);
    chk(fl_b0[7] == 8'h05, "R8", fl_b0[7], 8'h05);

    // R8: timeout after one sector
    busy_left = 0; erase_busy = 50;
    run_req(0, 2 * S, code);
    chk(code == 2, "R8", code, 2);
    chk(nfr == 11, "R8", nfr, 11);
    chk(fl_b0[2] == 8'hD8 && fl_addr[2] == 24'h0, "R8", fl_addr[2], 0);
    repeat (200) @(negedge clk);
    chk(nfr == 11, "R8", nfr, 11);
    busy_left = 0; erase_busy = 2;

    // R11: SPI clock idles low outside frames
    chk(idle_viol == 0, "R11", idle_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule